// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor with Return Stack

This block sits in the instruction fetch stage. Each cycle it takes the address of a 64-bit fetch word, looks it up in a small tagged table and reports whether a branch or jump that ends inside that word should be taken. If so, it gives the 16-bit slice where that instruction ends and the address to fetch next. Whether a conditional branch is taken comes from a separate direction predictor, one bit per slice. A taken prediction raises three signals together: a flush of younger fetch state, a load of the new fetch address, and a branch-history update strobe.

The table is split into ways. Each way is tied to a fixed pair of slices, so one fetch word can hold predictions for up to one branch per way. Targets for return-type jumps come from a four-entry circular return stack. A predicted call pushes the address that follows it, and a predicted return pops that address.

Execute sends corrections on a learn port. Only reports flagged as mispredicted are written into the table. Each accepted write holds fetch stalled for one cycle, so a lookup never sees a half-written entry.

Top module: `btb_fetch_predictor`

## Requirements
- R1: After reset the table is empty and the return stack pointer is zero. No fetch produces a redirect, and the stall output is low.
- R2: A learn report with the mispredict flag low does not stall fetch and does not change the table. A later fetch of that word still gives no redirect.
- R3: A learn report with the mispredict flag high raises the stall output for exactly the next cycle. No redirect is issued in that stalled cycle, even for a fetch that would hit.
- R4: After a mispredicted jump is learned at byte address P, a fetch of P's word whose slice offset (address bits 2:1) is at or below P's slice gives a redirect in the same cycle. The redirect carries the learned target and a slice output equal to P's bits 2:1.
- R5: A learned entry whose slice lies below the fetch slice offset is never predicted.
- R6: Learn kind encodings are 0 conditional, 1 jump, 2 call and 3 return. An entry of kind 0 at slice s is predicted only when bit s of the conditional-taken input is 1. The other kinds are always taken.
- R7: A lookup hits only if the upper address bits (31:7 by default) match the stored tag. A word with the same table index but a different tag gives no redirect.
- R8: Way w owns slices 2w and 2w+1. When several ways hit and are taken, the lowest slice at or above the fetch offset wins.
- R9: A predicted call pushes the word base plus 2×(slice+1). A later predicted return redirects to the top of the stack and pops it.
- R10: The return stack holds 4 entries and wraps. After five pushes with no pops, five returns yield the 5th, 4th, 3rd and 2nd pushed addresses and then the 5th again.
- R11: The flush and history-update outputs are high exactly in the cycles where the redirect valid output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A fetch address is presented this cycle |
| fetch_pc_i | input | 32 | Fetch byte address; bits 2:1 give the first live slice |
| cond_taken_i | input | 4 | Per-slice taken bit from the direction predictor |
| learn_valid_i | input | 1 | Learn report valid |
| learn_mispredict_i | input | 1 | The reported branch was mispredicted |
| learn_pc_i | input | 32 | Byte address of the branch's last slice |
| learn_kind_i | input | 2 | Branch kind, encoded as in R6 |
| learn_target_i | input | 32 | Resolved target |
| fetch_stall_o | output | 1 | Fetch must hold while a table write is in progress |
| flush_o | output | 1 | Flush younger fetch state |
| redirect_valid_o | output | 1 | Load redirect_pc_o into the fetch PC |
| redirect_pc_o | output | 32 | Predicted next fetch address |
| pred_slice_o | output | 2 | Slice index where the predicted branch ends |
| hist_update_o | output | 1 | Shift a taken outcome into the branch history |

## Verification
The assertions assume learn reports arrive only as single-cycle pulses, with fetch idle in the cycle a report is accepted. The bench keeps to this: each report is one pulse with fetch_valid_i low, followed by one stalled cycle. Random fetches draw from a small pool of word addresses, including pairs that share an index but differ in tag, so hits, misses and tag conflicts all occur. Learned addresses are always even, since slices are 16 bits wide.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    K_COND = 2'd0,
    K_JUMP = 2'd1,
    K_CALL = 2'd2,
    K_RET  = 2'd3
  } br_kind_t;
endpackage

// File: rtl/btb_way_bank.sv
module btb_way_bank #(
  parameter int PC_W   = 32,
  parameter int SETS   = 16,
  parameter int TAG_W  = 25,
  parameter int SLOT_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  input  logic [TAG_W-1:0]        rd_tag,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [1:0]              wr_kind,
  input  logic [PC_W-1:0]         wr_target,
  output logic                    hit,
  output logic [SLOT_W-1:0]       hit_slot,
  output logic [1:0]              hit_kind,
  output logic [PC_W-1:0]         hit_target
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SLOT_W-1:0] slot_q [SETS];
  logic [1:0]        kind_q [SETS];
  logic [PC_W-1:0]   tgt_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      slot_q[wr_idx] <= wr_slot;
      kind_q[wr_idx] <= wr_kind;
      tgt_q[wr_idx]  <= wr_target;
    end
  end

  assign hit        = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign hit_slot   = slot_q[rd_idx];
  assign hit_kind   = kind_q[rd_idx];
  assign hit_target = tgt_q[rd_idx];
endmodule

// File: rtl/btb_select.sv
module btb_select #(
  parameter int WAYS   = 2,
  parameter int SPW    = 2,
  parameter int SLICES = 4,
  parameter int SLOT_W = 1,
  parameter int OFF_W  = 2,
  parameter int WAY_W  = 1
) (
  input  logic [WAYS-1:0]             way_hit,
  input  logic [WAYS-1:0][SLOT_W-1:0] way_slot,
  input  logic [WAYS-1:0][1:0]        way_kind,
  input  logic [SLICES-1:0]           cond_taken,
  input  logic [OFF_W-1:0]            fetch_off,
  output logic                        sel_valid,
  output logic [WAY_W-1:0]            sel_way,
  output logic [OFF_W-1:0]            sel_slice
);
  import btb_pkg::*;

  // Walk from the highest way down so the lowest qualifying slice is kept.
  always_comb begin
    sel_valid = 1'b0;
    sel_way   = '0;
    sel_slice = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      int  s;
      logic take;
      s    = w * SPW + int'(way_slot[w]);
      take = (way_kind[w] == K_COND) ? cond_taken[s] : 1'b1;
      if (way_hit[w] && (s >= int'(fetch_off)) && take) begin
        sel_valid = 1'b1;
        sel_way   = WAY_W'(w);
        sel_slice = OFF_W'(s);
      end
    end
  end
endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_addr,
  output logic [PC_W-1:0] top
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] ptr_q;
  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_up;

  assign ptr_up = ptr_q + PTR_W'(1);

  // Circular storage: a push past the depth overwrites the oldest entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[ptr_up] <= push_addr;
      ptr_q         <= ptr_up;
    end else if (pop) begin
      ptr_q <= ptr_q - PTR_W'(1);
    end
  end

  assign top = mem_q[ptr_q];
endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor #(
  parameter int PC_W      = 32,
  parameter int SLICES    = 4,
  parameter int WAYS      = 2,
  parameter int SETS      = 16,
  parameter int RAS_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fetch_valid_i,
  input  logic [PC_W-1:0]           fetch_pc_i,
  input  logic [SLICES-1:0]         cond_taken_i,
  input  logic                      learn_valid_i,
  input  logic                      learn_mispredict_i,
  input  logic [PC_W-1:0]           learn_pc_i,
  input  logic [1:0]                learn_kind_i,
  input  logic [PC_W-1:0]           learn_target_i,
  output logic                      fetch_stall_o,
  output logic                      flush_o,
  output logic                      redirect_valid_o,
  output logic [PC_W-1:0]           redirect_pc_o,
  output logic [$clog2(SLICES)-1:0] pred_slice_o,
  output logic                      hist_update_o
);
  import btb_pkg::*;

  localparam int SPW    = SLICES / WAYS;
  localparam int OFF_W  = $clog2(SLICES);
  localparam int BYTE_W = OFF_W + 1;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = PC_W - BYTE_W - IDX_W;
  localparam int SLOT_W = (SPW > 1) ? $clog2(SPW) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Address of the instruction after the one ending in the given slice.
  function automatic logic [PC_W-1:0] next_after_slice(input logic [PC_W-1:0] pc,
                                                       input logic [OFF_W-1:0] slice);
    logic [PC_W-1:0] base;
    base = {pc[PC_W-1:BYTE_W], {BYTE_W{1'b0}}};
    return base + ((PC_W'(slice) + PC_W'(1)) << 1);
  endfunction

  // Pending learn write, applied one cycle after acceptance.
  logic              pend_v;
  logic [IDX_W-1:0]  pend_idx;
  logic [TAG_W-1:0]  pend_tag;
  logic [OFF_W-1:0]  pend_slice;
  logic [1:0]        pend_kind;
  logic [PC_W-1:0]   pend_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= learn_valid_i && learn_mispredict_i;
  end

  always_ff @(posedge clk) begin
    pend_idx   <= learn_pc_i[BYTE_W +: IDX_W];
    pend_tag   <= learn_pc_i[PC_W-1 -: TAG_W];
    pend_slice <= learn_pc_i[BYTE_W-1:1];
    pend_kind  <= learn_kind_i;
    pend_tgt   <= learn_target_i;
  end

  logic unused_pc_bits;
  assign unused_pc_bits = fetch_pc_i[0] ^ learn_pc_i[0];

  logic [WAYS-1:0]             w_hit;
  logic [WAYS-1:0][SLOT_W-1:0] w_slot;
  logic [WAYS-1:0][1:0]        w_kind;
  logic [WAYS-1:0][PC_W-1:0]   w_tgt;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_here;
    assign wr_here = pend_v && (int'(pend_slice) / SPW == w);
    btb_way_bank #(.PC_W(PC_W), .SETS(SETS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (fetch_pc_i[BYTE_W +: IDX_W]),
      .rd_tag    (fetch_pc_i[PC_W-1 -: TAG_W]),
      .wr_en     (wr_here),
      .wr_idx    (pend_idx),
      .wr_tag    (pend_tag),
      .wr_slot   (SLOT_W'(int'(pend_slice) % SPW)),
      .wr_kind   (pend_kind),
      .wr_target (pend_tgt),
      .hit       (w_hit[w]),
      .hit_slot  (w_slot[w]),
      .hit_kind  (w_kind[w]),
      .hit_target(w_tgt[w])
    );
  end

  logic             sel_valid;
  logic [WAY_W-1:0] sel_way;
  logic [OFF_W-1:0] sel_slice;

  btb_select #(.WAYS(WAYS), .SPW(SPW), .SLICES(SLICES), .SLOT_W(SLOT_W),
               .OFF_W(OFF_W), .WAY_W(WAY_W)) u_sel (
    .way_hit   (w_hit),
    .way_slot  (w_slot),
    .way_kind  (w_kind),
    .cond_taken(cond_taken_i),
    .fetch_off (fetch_pc_i[BYTE_W-1:1]),
    .sel_valid (sel_valid),
    .sel_way   (sel_way),
    .sel_slice (sel_slice)
  );

  // Named internal events, visible to the bound checker.
  logic            lookup_en;
  logic            take_event;
  logic [1:0]      sel_kind;
  logic            ras_push;
  logic            ras_pop;
  logic [PC_W-1:0] ras_top;

  assign lookup_en  = fetch_valid_i && !pend_v;
  assign take_event = lookup_en && sel_valid;
  assign sel_kind   = w_kind[sel_way];
  assign ras_push   = take_event && (sel_kind == K_CALL);
  assign ras_pop    = take_event && (sel_kind == K_RET);

  btb_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ras_push),
    .pop      (ras_pop),
    .push_addr(next_after_slice(fetch_pc_i, sel_slice)),
    .top      (ras_top)
  );

  assign fetch_stall_o    = pend_v;
  assign redirect_valid_o = take_event;
  assign flush_o          = take_event;
  assign hist_update_o    = take_event;
  assign redirect_pc_o    = (sel_kind == K_RET) ? ras_top : w_tgt[sel_way];
  assign pred_slice_o     = sel_slice;
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid_i,
  input logic [OFF_W:1]   fetch_off,
  input logic             learn_valid_i,
  input logic             learn_mispredict_i,
  input logic             fetch_stall_o,
  input logic             flush_o,
  input logic             redirect_valid_o,
  input logic [OFF_W-1:0] pred_slice_o,
  input logic             hist_update_o,
  input logic             ras_push,
  input logic             ras_pop
);
  a_r3_stall_after_learn: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_valid_i && learn_mispredict_i) |=> fetch_stall_o);

  a_r2_no_stall_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(learn_valid_i && learn_mispredict_i) |=> !fetch_stall_o);

  a_r3_quiet_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |-> !redirect_valid_o);

  a_r11_flush_and_history: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> (flush_o && hist_update_o));

  a_r11_no_stray_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o || hist_update_o) |-> redirect_valid_o);

  a_r1_redirect_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> fetch_valid_i);

  a_r5_slice_not_before_offset: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> (pred_slice_o >= fetch_off));

  a_r9_push_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ras_push, ras_pop}));
endmodule

bind btb_fetch_predictor btb_checker #(.OFF_W(OFF_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .fetch_valid_i     (fetch_valid_i),
  .fetch_off         (fetch_pc_i[OFF_W:1]),
  .learn_valid_i     (learn_valid_i),
  .learn_mispredict_i(learn_mispredict_i),
  .fetch_stall_o     (fetch_stall_o),
  .flush_o           (flush_o),
  .redirect_valid_o  (redirect_valid_o),
  .pred_slice_o      (pred_slice_o),
  .hist_update_o     (hist_update_o),
  .ras_push          (ras_push),
  .ras_pop           (ras_pop)
);

// File: tb/sim_btb_fetch_predictor.sv
`timescale 1ns/100ps
module sim_btb_fetch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic [3:0]  cond_taken_i = '0;
  logic        learn_valid_i = 1'b0;
  logic        learn_mispredict_i = 1'b0;
  logic [31:0] learn_pc_i = '0;
  logic [1:0]  learn_kind_i = '0;
  logic [31:0] learn_target_i = '0;
  logic        fetch_stall_o, flush_o, redirect_valid_o, hist_update_o;
  logic [31:0] redirect_pc_o;
  logic [1:0]  pred_slice_o;

  always #2.5 clk = ~clk;

  btb_fetch_predictor u0 (.*);

  int checks = 0;
  int failures = 0;

  // Reference model: 16 sets x 2 ways, plus a 4-entry ring stack.
  bit          m_v   [16][2];
  logic [24:0] m_tag [16][2];
  bit          m_slot[16][2];
  logic [1:0]  m_kind[16][2];
  logic [31:0] m_tgt [16][2];
  logic [31:0] r_mem [4];
  int          r_ptr;
  bit          e_v;
  logic [1:0]  e_slice;
  logic [31:0] e_pc;
  logic [1:0]  e_kind;
  logic [31:0] pool [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_predict(input logic [31:0] pc, input logic [3:0] cond);
    int idx = int'(pc[6:3]);
    e_v = 1'b0; e_slice = '0; e_pc = '0; e_kind = '0;
    for (int s = 3; s >= int'(pc[2:1]); s--) begin
      int w = s / 2;
      if (m_v[idx][w] && m_tag[idx][w] == pc[31:7] && int'(m_slot[idx][w]) == s % 2 &&
          (m_kind[idx][w] != 2'd0 || cond[s])) begin
        e_v = 1'b1; e_slice = 2'(s); e_kind = m_kind[idx][w];
        e_pc = (m_kind[idx][w] == 2'd3) ? r_mem[r_ptr] : m_tgt[idx][w];
      end
    end
  endfunction

  task automatic do_fetch(input logic [31:0] pc, input logic [3:0] cond, input string req);
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_pc_i = pc; cond_taken_i = cond;
    #1;
    model_predict(pc, cond);
    chk(redirect_valid_o == e_v, req, 32'(redirect_valid_o), 32'(e_v));
    chk(flush_o == e_v && hist_update_o == e_v, "R11", {flush_o, hist_update_o}, {e_v, e_v});
    if (e_v) begin
      chk(redirect_pc_o == e_pc, req, redirect_pc_o, e_pc);
      chk(pred_slice_o == e_slice, req, 32'(pred_slice_o), 32'(e_slice));
      if (e_kind == 2'd2) begin
        r_ptr = (r_ptr + 1) % 4;
        r_mem[r_ptr] = {pc[31:3], 3'b0} + 32'((int'(e_slice) + 1) * 2);
      end else if (e_kind == 2'd3) begin
        r_ptr = (r_ptr + 3) % 4;
      end
    end
  endtask

  task automatic do_learn(input logic [31:0] pc, input logic [1:0] kind, input logic [31:0] tgt, input bit misp);
    @(negedge clk);
    fetch_valid_i = 1'b0;
    learn_valid_i = 1'b1; learn_mispredict_i = misp;
    learn_pc_i = pc; learn_kind_i = kind; learn_target_i = tgt;
    @(negedge clk);
    learn_valid_i = 1'b0;
    fetch_valid_i = 1'b1; fetch_pc_i = {pc[31:3], 3'b0}; cond_taken_i = 4'hF;
    #1;
    chk(fetch_stall_o == misp, misp ? "R3" : "R2", 32'(fetch_stall_o), 32'(misp));
    if (misp) chk(!redirect_valid_o, "R3", 32'(redirect_valid_o), 32'd0);
    if (misp) begin
      int idx = int'(pc[6:3]);
      int w = int'(pc[2]);
      m_v[idx][w] = 1'b1; m_tag[idx][w] = pc[31:7]; m_slot[idx][w] = pc[1];
      m_kind[idx][w] = kind; m_tgt[idx][w] = tgt;
    end
    // With misp low this fetch may hit an older entry; keep the stack model in step.
    if (!misp) begin
      model_predict(fetch_pc_i, 4'hF);
      if (e_v && e_kind == 2'd2) begin
        r_ptr = (r_ptr + 1) % 4;
        r_mem[r_ptr] = fetch_pc_i + 32'((int'(e_slice) + 1) * 2);
      end else if (e_v && e_kind == 2'd3) r_ptr = (r_ptr + 3) % 4;
    end
    @(negedge clk);
    fetch_valid_i = 1'b0;
    #1;
    chk(!fetch_stall_o, misp ? "R3" : "R2", 32'(fetch_stall_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 16; i++) for (int w = 0; w < 2; w++) m_v[i][w] = 1'b0;
    for (int i = 0; i < 4; i++) r_mem[i] = '0;
    r_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!fetch_stall_o && !redirect_valid_o, "R1", {fetch_stall_o, redirect_valid_o}, 32'd0);
    do_fetch(32'h0000_1040, 4'hF, "R1");

    // R2: a correctly predicted report leaves the table untouched
    do_learn(32'h0000_2014, 2'd1, 32'h0000_9000, 1'b0);
    do_fetch(32'h0000_2010, 4'hF, "R2");

    // R4 and R5: jump ending in slice 2
    do_learn(32'h0000_2014, 2'd1, 32'h0000_9000, 1'b1);
    do_fetch(32'h0000_2010, 4'h0, "R4");
    do_fetch(32'h0000_2014, 4'h0, "R4");
    do_fetch(32'h0000_2016, 4'h0, "R5");
    // R7: same index, different tag
    do_fetch(32'h0010_2010, 4'hF, "R7");

    // R6: conditional at slice 1
    do_learn(32'h0000_3022, 2'd0, 32'h0000_A000, 1'b1);
    do_fetch(32'h0000_3020, 4'b0000, "R6");
    do_fetch(32'h0000_3020, 4'b1101, "R6");
    do_fetch(32'h0000_3020, 4'b0010, "R6");

    // R8: one branch per way in the same word
    do_learn(32'h0000_4032, 2'd1, 32'h0000_B000, 1'b1);
    do_learn(32'h0000_4036, 2'd1, 32'h0000_C000, 1'b1);
    do_fetch(32'h0000_4030, 4'h0, "R8");
    do_fetch(32'h0000_4034, 4'h0, "R8");

    // R9: call then return
    do_learn(32'h0000_5040, 2'd2, 32'h0000_D000, 1'b1);
    do_learn(32'h0000_6056, 2'd3, 32'h0000_0000, 1'b1);
    do_fetch(32'h0000_5040, 4'h0, "R9");
    do_fetch(32'h0000_6050, 4'h0, "R9");
    chk(e_pc == 32'h0000_5042, "R9", e_pc, 32'h0000_5042);

    // R10: five calls, five returns, wrap
    for (int k = 0; k < 5; k++)
      do_learn(32'h0001_0000 + 32'(k * 8) + 32'h8 * 32'h10, 2'd2, 32'h0000_E000, 1'b1);
    for (int k = 0; k < 5; k++)
      do_fetch(32'h0001_0000 + 32'(k * 8) + 32'h80, 4'h0, "R10");
    for (int k = 0; k < 5; k++) begin
      logic [31:0] want;
      want = 32'h0001_0082 + 32'((k == 4 ? 4 : 4 - k) * 8);
      do_fetch(32'h0000_6050, 4'h0, "R10");
      chk(e_pc == want, "R10", e_pc, want);
    end

    // Random mix against the model
    for (int i = 0; i < 8; i++)
      pool[i] = {($urandom_range(0, 1) == 0) ? 25'h0000100 : 25'h0000233, 4'($urandom_range(0, 15)), 3'b0};
    for (int n = 0; n < 400; n++) begin
      logic [31:0] p;
      p = pool[$urandom_range(0, 7)];
      if ($urandom_range(0, 9) < 3)
        do_learn(p + 32'($urandom_range(0, 3) * 2), 2'($urandom_range(0, 3)),
                 {$urandom(), 1'b0} >> 1 << 1, 1'($urandom_range(0, 3) != 0));
      else
        do_fetch(p + 32'($urandom_range(0, 3) * 2), 4'($urandom_range(0, 15)), "R8");
    end

    @(negedge clk); fetch_valid_i = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule